// File: doc/BRIEF.md
# Multi-Port GPIO Controller with Edge Interrupts

This block is a memory-mapped general purpose I/O peripheral. It groups pins into 8-bit ports, and each port has its own register bank and its own interrupt line. For every pin, software can choose among four settings: input, push-pull output, open-drain output or open-source output. Software can also set the output value, turn the pull-up on or off, and select whether a rising or a falling edge raises a sticky event flag. Pad inputs pass through a two-flop synchronizer before they are read back or checked for edges.

Software reaches the block over a simple 32-bit register bus. A write takes effect on the next clock edge. A read returns data in the same cycle. A global control word at address 0x00 reports how many ports are fitted and a version number. Its lowest bit is a run enable: while it is 0, no new events are recorded. Each port interrupt goes high while any of the port's events is both pending and enabled. A force register lets a test raise event flags without any pad activity.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Port p (0 to NUM_PORTS-1) has a bank at byte address p*0x30. Within a bank, the registers sit at these offsets: input data 0x04 (read-only), output data 0x08, mode 0x0C, pull-up disable 0x10, event 0x14, interrupt enable 0x18, force 0x1C and edge select 0x20. A value written to a read/write register reads back on the next cycle.
- R2: After reset, every read/write register is 0. As a result, every pad_oe bit is 0, every pad_pu bit is 1, every irq bit is 0, and every port register reads 0.
- R3: Address 0x00 reads {16'b0, NUM_PORTS[6:0], VERSION[6:0], ctl[1:0]}. Only bits 1..0 are writable. Bit 0 is the run enable and bit 1 is a sync-select bit that is stored only.
- R4: The input data register returns the pad level two clock edges after the pad changes. Writes to it are ignored.
- R5: Pin n's mode is held in bits [2n+1:2n] of the mode register. The codes are: 0 = input (not driven); 1 = push-pull (always driven to the data bit); 2 = open-drain (driven low only when the data bit is 0); 3 = open-source (driven high only when the data bit is 1). pad_out is 0 wherever pad_oe is 0.
- R6: A 1 in a bit of the pull-up disable register turns that pin's pad_pu off, and a 0 turns it on. pad_pu changes only after a register write.
- R7: An edge-select bit of 1 detects rising edges and 0 detects falling edges; the opposite edge is ignored. The event flag is set three clock edges after the pad change.
- R8: Writing 1 to an event bit clears it, and writing 0 leaves it unchanged. If a new edge arrives in the same cycle as the clear, the flag stays set.
- R9: irq[p] is the OR over the port's 8 pins of (event AND enable).
- R10: While a force bit is 1, the matching event flag is set on the next clock edge. A force value of 0 forces nothing.
- R11: While control bit 0 is 0, neither edges nor force bits set event flags.
- R12: Reads return 0 for unused register bits, for unused offsets, and for addresses at or above NUM_PORTS*0x30.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| pad_in | input | NUM_PORTS*8 | Pad input levels |
| pad_out | output | NUM_PORTS*8 | Pad output values |
| pad_oe | output | NUM_PORTS*8 | Pad output enables |
| pad_pu | output | NUM_PORTS*8 | Pad pull-up enables |
| irq | output | NUM_PORTS | One interrupt per port |

## Verification
Each result is due at a fixed latency. Register writes, pad drive and pull-up changes are visible one clock edge after the write. Force-driven events appear one edge after the force value is stored. The input-data view updates two edges after a pad change, and edge events plus irq appear on the third edge. The bench changes inputs on falling clock edges and counts falling edges before it samples. At the latency boundaries it checks both sides: the value one edge before the result is due and the value once it is due. The clear-versus-edge collision is built by placing the clear write exactly on the third edge after the pad change.

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl #(
  parameter int NUM_PORTS = 7,
  parameter int ADDR_W = 9,
  parameter int STRIDE = 48,
  parameter logic [6:0] VERSION = 7'd5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  input  logic [NUM_PORTS*8-1:0]    pad_in,
  output logic [NUM_PORTS*8-1:0]    pad_out,
  output logic [NUM_PORTS*8-1:0]    pad_oe,
  output logic [NUM_PORTS*8-1:0]    pad_pu,
  output logic [NUM_PORTS-1:0]      irq
);
  localparam int PINS = 8;
  localparam int SPAN = NUM_PORTS * STRIDE;
  localparam logic [ADDR_W-1:0] OFS_CTL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_DIN  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_DOUT = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFS_MODE = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] OFS_PUD  = ADDR_W'(16);
  localparam logic [ADDR_W-1:0] OFS_EVT  = ADDR_W'(20);
  localparam logic [ADDR_W-1:0] OFS_IEN  = ADDR_W'(24);
  localparam logic [ADDR_W-1:0] OFS_FRC  = ADDR_W'(28);
  localparam logic [ADDR_W-1:0] OFS_EDGE = ADDR_W'(32);

  logic [1:0]        ctl_r;
  logic              run;
  logic              in_range;
  logic [ADDR_W-1:0] a_port, a_ofs;
  logic [31:0]       ctl_word, rd_mux;
  logic [31:0]       port_rd [NUM_PORTS];
  logic              wdata_unused;

  assign run          = ctl_r[0];
  assign in_range     = bus_addr < ADDR_W'(SPAN);
  assign a_port       = bus_addr / ADDR_W'(STRIDE);
  assign a_ofs        = bus_addr % ADDR_W'(STRIDE);
  assign ctl_word     = {16'b0, 7'(NUM_PORTS), VERSION, ctl_r};
  assign wdata_unused = ^bus_wdata[31:16];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_r <= '0;
    else if (bus_wr && bus_addr == OFS_CTL) ctl_r <= bus_wdata[1:0];
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [PINS-1:0]   s1, s2, s3, dout, pud, ien, evt, frc, edg;
    logic [PINS-1:0]   hit, clr, drv_o, drv_e;
    logic [2*PINS-1:0] mode;
    logic              we;
    logic [31:0]       rd;

    assign we  = bus_wr && in_range && (a_port == ADDR_W'(p));
    assign hit = (edg & s2 & ~s3) | (~edg & ~s2 & s3);
    assign clr = (we && a_ofs == OFS_EVT) ? bus_wdata[PINS-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= '0; s2 <= '0; s3 <= '0;
        dout <= '0; mode <= '0; pud <= '0; ien <= '0;
        evt <= '0; frc <= '0; edg <= '0;
      end else begin
        s1 <= pad_in[p*PINS +: PINS];
        s2 <= s1;
        s3 <= s2;
        if (we && a_ofs == OFS_DOUT) dout <= bus_wdata[PINS-1:0];
        if (we && a_ofs == OFS_MODE) mode <= bus_wdata[2*PINS-1:0];
        if (we && a_ofs == OFS_PUD)  pud  <= bus_wdata[PINS-1:0];
        if (we && a_ofs == OFS_IEN)  ien  <= bus_wdata[PINS-1:0];
        if (we && a_ofs == OFS_FRC)  frc  <= bus_wdata[PINS-1:0];
        if (we && a_ofs == OFS_EDGE) edg  <= bus_wdata[PINS-1:0];
        evt <= (evt & ~clr) | (run ? (hit | frc) : '0);
      end
    end

    always_comb begin
      for (int i = 0; i < PINS; i++) begin
        case (mode[2*i +: 2])
          2'd1:    begin drv_e[i] = 1'b1;     drv_o[i] = dout[i]; end
          2'd2:    begin drv_e[i] = ~dout[i]; drv_o[i] = 1'b0;    end
          2'd3:    begin drv_e[i] = dout[i];  drv_o[i] = dout[i]; end
          default: begin drv_e[i] = 1'b0;     drv_o[i] = 1'b0;    end
        endcase
      end
    end

    always_comb begin
      case (a_ofs)
        OFS_DIN:  rd = {24'b0, s2};
        OFS_DOUT: rd = {24'b0, dout};
        OFS_MODE: rd = {16'b0, mode};
        OFS_PUD:  rd = {24'b0, pud};
        OFS_EVT:  rd = {24'b0, evt};
        OFS_IEN:  rd = {24'b0, ien};
        OFS_FRC:  rd = {24'b0, frc};
        OFS_EDGE: rd = {24'b0, edg};
        default:  rd = '0;
      endcase
    end

    assign port_rd[p]              = rd;
    assign pad_out[p*PINS +: PINS] = drv_o;
    assign pad_oe[p*PINS +: PINS]  = drv_e;
    assign pad_pu[p*PINS +: PINS]  = ~pud;
    assign irq[p]                  = |(evt & ien);
  end

  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (a_port == ADDR_W'(p)) rd_mux = port_rd[p];
  end

  assign bus_rdata = !in_range             ? 32'd0 :
                     (bus_addr == OFS_CTL) ? ctl_word : rd_mux;
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
  parameter int NUM_PORTS = 7,
  parameter int ADDR_W = 9,
  parameter int STRIDE = 48
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_wr,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic [7:0]             bus_wdata,
  input logic [31:0]            bus_rdata,
  input logic [NUM_PORTS*8-1:0] pad_out,
  input logic [NUM_PORTS*8-1:0] pad_oe,
  input logic [NUM_PORTS*8-1:0] pad_pu
);
  localparam int SPAN = NUM_PORTS * STRIDE;

  // R5
  undriven_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0);

  // R12
  absent_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr >= ADDR_W'(SPAN)) |-> bus_rdata == 32'd0);

  // R6
  pull_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(bus_wr)) |-> $stable(pad_pu));

  // R1
  dout_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(bus_wr) && $past(bus_addr) == ADDR_W'(8) &&
     !bus_wr && bus_addr == ADDR_W'(8)) |-> bus_rdata == {24'b0, $past(bus_wdata)});
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(
  .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .STRIDE(STRIDE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata[7:0]), .bus_rdata(bus_rdata),
  .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
);

// File: tb/gpio_bank_ctrl_test.sv
module gpio_bank_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 7;
  localparam int AW = 9;
  localparam int PW = NP * 8;
  // {mode[1:0], data, expected oe, expected out}
  localparam logic [4:0] DRV_TAB [8] = '{
    5'b00_0_0_0, 5'b00_1_0_0, 5'b01_0_1_0, 5'b01_1_1_1,
    5'b10_0_1_0, 5'b10_1_0_0, 5'b11_0_0_0, 5'b11_1_1_1
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [PW-1:0] pad_in = '0;
  logic [PW-1:0] pad_out, pad_oe, pad_pu;
  logic [NP-1:0] irq;
  int            n_chk = 0;
  int            n_bad = 0;
  bit            done = 1'b0;

  gpio_bank_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(addr); bus_wdata = data;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rdchk(input string tag, input int addr, input logic [31:0] exp);
    bus_addr = AW'(addr);
    #1;
    check(tag, 64'(bus_rdata), 64'(exp));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    check("R2 pad_oe", 64'(pad_oe), 64'(0));
    check("R2 pad_pu", 64'(pad_pu), 64'({PW{1'b1}}));
    check("R2 irq", 64'(irq), 64'(0));
    rdchk("R2 dout p2", 8'h68, 32'h0);
    rdchk("R2 mode p2", 8'h6C, 32'h0);
    // R3 control word
    rdchk("R3 ctl reset", 0, 32'h0000_0E14);
    wr(0, 32'hFFFF_FFFF);
    rdchk("R3 ctl write ones", 0, 32'h0000_0E17);
    wr(0, 32'h1);
    rdchk("R3 ctl run", 0, 32'h0000_0E15);

    // R5 drive mode table on port 2 pin 3
    for (int k = 0; k < 8; k++) begin
      wr(8'h6C, 32'(DRV_TAB[k][4:3]) << 6);
      wr(8'h68, 32'(DRV_TAB[k][2]) << 3);
      check($sformatf("R5 oe entry %0d", k), 64'(pad_oe[19]), 64'(DRV_TAB[k][1]));
      check($sformatf("R5 out entry %0d", k), 64'(pad_out[19]), 64'(DRV_TAB[k][0]));
    end
    rdchk("R1 mode readback", 8'h6C, 32'h0000_00C0);

    // R6 pull-up disable
    wr(8'h10, 32'hA5);
    check("R6 pad_pu port0", 64'(pad_pu[7:0]), 64'h5A);
    rdchk("R6 pud readback", 8'h10, 32'hA5);

    // R4 input data latency and write ignore
    @(negedge clk); pad_in[31:24] = 8'h3C;
    @(negedge clk); rdchk("R4 din one edge", 8'h94, 32'h0);
    @(negedge clk); rdchk("R4 din two edges", 8'h94, 32'h3C);
    wr(8'h94, 32'hFF);
    rdchk("R4 din write ignored", 8'h94, 32'h3C);

    // R7 rising edge on port 1 pin 0
    wr(8'h50, 32'h01);
    wr(8'h48, 32'h01);
    @(negedge clk); pad_in[8] = 1'b1;
    @(negedge clk); @(negedge clk);
    rdchk("R7 evt not yet", 8'h44, 32'h0);
    check("R9 irq not yet", 64'(irq[1]), 64'(0));
    @(negedge clk);
    rdchk("R7 evt after 3 edges", 8'h44, 32'h1);
    check("R9 irq raised", 64'(irq[1]), 64'(1));
    wr(8'h44, 32'h1);
    rdchk("R8 evt cleared", 8'h44, 32'h0);
    check("R9 irq cleared", 64'(irq[1]), 64'(0));

    // R7 falling-edge pin ignores rising
    @(negedge clk); pad_in[9] = 1'b1;
    repeat (4) @(negedge clk);
    rdchk("R7 rising ignored", 8'h44, 32'h0);
    pad_in[9] = 1'b0;
    repeat (3) @(negedge clk);
    rdchk("R7 falling caught", 8'h44, 32'h2);
    check("R9 disabled pin no irq", 64'(irq[1]), 64'(0));
    wr(8'h48, 32'h3);
    check("R9 enable raises irq", 64'(irq[1]), 64'(1));

    // R8 partial clear
    pad_in[8] = 1'b0;
    repeat (4) @(negedge clk);
    pad_in[8] = 1'b1;
    repeat (3) @(negedge clk);
    rdchk("R8 both set", 8'h44, 32'h3);
    wr(8'h44, 32'h2);
    rdchk("R8 partial clear", 8'h44, 32'h1);

    // R8 edge wins over same-cycle clear
    pad_in[8] = 1'b0;
    repeat (4) @(negedge clk);
    pad_in[8] = 1'b1;
    @(negedge clk); @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(8'h44); bus_wdata = 32'h1;
    @(negedge clk);
    bus_wr = 1'b0;
    rdchk("R8 edge wins", 8'h44, 32'h1);
    wr(8'h44, 32'h1);
    rdchk("R8 cleared after", 8'h44, 32'h0);

    // R10 force register on port 4
    wr(8'hDC, 32'h80);
    rdchk("R10 force not yet", 8'hD4, 32'h0);
    @(negedge clk);
    rdchk("R10 force sets", 8'hD4, 32'h80);
    wr(8'hDC, 32'h0);
    wr(8'hD4, 32'hFF);
    @(negedge clk);
    rdchk("R10 zero force idle", 8'hD4, 32'h0);

    // R11 run disabled
    wr(0, 32'h0);
    wr(8'hDC, 32'h01);
    repeat (3) @(negedge clk);
    rdchk("R11 no event when off", 8'hD4, 32'h0);
    wr(0, 32'h1);
    @(negedge clk);
    rdchk("R11 event after run", 8'hD4, 32'h1);
    wr(8'hDC, 32'h0);
    wr(8'hD4, 32'h1);

    // R12 unused bits, offsets, absent ports
    rdchk("R12 absent port", 9'h150, 32'h0);
    rdchk("R12 top address", 9'h1FC, 32'h0);
    rdchk("R12 unused offset", 8'h24, 32'h0);
    rdchk("R12 port offset zero", 8'h30, 32'h0);
    wr(8'h08, 32'hFFFF_FFFF);
    rdchk("R12 dout upper bits", 8'h08, 32'h0000_00FF);
    wr(8'h0C, 32'hFFFF_FFFF);
    rdchk("R12 mode upper bits", 8'h0C, 32'h0000_FFFF);
    check("R5 open-source all high oe", 64'(pad_oe[7:0]), 64'hFF);
    check("R5 open-source all high out", 64'(pad_out[7:0]), 64'hFF);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule